// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Return Stack

This block decides which pending interrupt a processor core takes next and keeps the return addresses for interrupts and subroutine calls. Sources are a reset request, a nonmaskable interrupt, three external active-low lines and four internal pulse sources: serial receive, serial transmit, timer and UART. External lines and the nonmaskable line pass through a two-stage synchronizer, and a falling edge records a request. Maskable requests sit in a flag register that software can also set and clear. A mask register and a global-disable bit gate the flags before a fixed-priority pick.

The chosen request is offered to the core as a valid/ready pair carrying a vector address. `irq_valid` and `irq_vec` are combinational from the pending state and `busy`. The core asserts `irq_ready` at an instruction boundary, and the request is taken in any cycle where both are high. While `irq_valid` is high and `irq_ready` is low, nothing is consumed. The offered vector may move to a newly arrived higher-priority source, and `irq_valid` drops while `busy` is high. Nothing is lost in either case.

When an interrupt is taken, the return address on `pc_in` is pushed onto an eight-entry shift stack. Subroutine calls push onto the same stack and returns pop it. The top entry is always visible on `ret_pc`.

Top module: `irq_ctrl_stack`

## Requirements
- R1: After reset, `flag_q` and `mask_q` are zero, `gdis_q` is 1, `stk_level` is 0, `stk_ovf` is 0 and `irq_valid` is 0.
- R2: A falling edge on an external line sets its flag three clock edges after the line is first sampled low. A line held low sets the flag only once. A one-cycle pulse on an internal source sets its flag at the next edge. The flag bit order is external lines 0..2 at bits 0..2, then serial receive, serial transmit, timer and UART at bits 3..6.
- R3: A one in `flag_set` sets a flag and a one in `flag_clr` clears it. Clear wins over set. `flag_q` always shows the flags.
- R4: A maskable flag is offered only when its `mask_q` bit is 1 and `gdis_q` is 0. Flags that are gated off stay set.
- R5: The priority order is reset first, then NMI, then maskable flags with the lower bit first. UART is lowest. `irq_vec` is twice the source number, where reset is 0, NMI is 1 and flag bit k is k+2.
- R6: While `busy` is high, `irq_valid` is 0 and no request is taken.
- R7: Taking a maskable request pushes `pc_in`, clears that flag and sets `gdis_q`.
- R8: NMI is taken regardless of masks and `gdis_q`. Taking it pushes `pc_in` and leaves `gdis_q` unchanged.
- R9: Taking a reset request pushes nothing. It empties the stack, clears `stk_ovf` and sets `gdis_q`.
- R10: `call_push` pushes `pc_in` and `ret_pop` pops. `ret_pc` shows the top entry. If both are high, only the push happens. Both are ignored in a cycle where a request is taken.
- R11: A push with eight entries stored drops the oldest entry, keeps `stk_level` at 8 and sets `stk_ovf`, which stays set until a reset request is taken.
- R12: A pop with the stack empty keeps `stk_level` at 0. `ret_pc` then shows the deepest stored value, which pops do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_irq | input | 1 | Reset-request pulse, highest priority |
| nmi_n | input | 1 | Nonmaskable interrupt, active low, edge-triggered |
| ext_irq_n | input | 3 | External interrupt lines, active low, edge-triggered |
| int_irq | input | 4 | Internal source pulses: serial rx, serial tx, timer, UART |
| flag_set | input | 7 | Software set of flag bits |
| flag_clr | input | 7 | Software clear of flag bits |
| flag_q | output | 7 | Pending flags |
| mask_we | input | 1 | Mask register write enable |
| mask_d | input | 7 | Mask write data (1 = enabled) |
| mask_q | output | 7 | Mask register |
| gdis_clr | input | 1 | Clears the global-disable bit |
| gdis_q | output | 1 | Global disable of maskable sources |
| busy | input | 1 | Multicycle instruction in progress |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | Core takes the offered request |
| irq_vec | output | 5 | Vector address of the offered request |
| pc_in | input | 16 | Return address to push |
| call_push | input | 1 | Subroutine call push |
| ret_pop | input | 1 | Return pop |
| ret_pc | output | 16 | Top stack entry |
| stk_level | output | 4 | Number of stored entries |
| stk_ovf | output | 1 | Sticky stack overflow |

## Verification
A corrupted flag or mask bit shows on `irq_valid` and `irq_vec` in the same cycle, because the offer is combinational from the stored state. A stuck synchronizer stage shows as a missing or late flag three edges after a line falls. A wrong stack pointer or shifted entry stays hidden until the next pop, when `ret_pc` or `stk_level` disagrees with the expected return order. A lost overflow or global-disable update shows on the next edge through `stk_ovf` or `gdis_q`.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_RESET,
    SRC_NMI,
    SRC_MASKABLE
  } src_kind_e;

  // source number of the first maskable flag (reset = 0, NMI = 1)
  localparam int MASK_BASE = 2;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_n,
  output logic [W-1:0] fall
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= line_n[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign fall[g] = s3 & ~s2;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] top,
  output logic [LW-1:0] level,
  output logic          ovf
);
  logic [DW-1:0] ent [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      level <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      ent[0] <= din;
      for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
      if (level == LW'(DEPTH)) ovf <= 1'b1;
      else                     level <= level + 1'b1;
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
      if (level != '0) level <= level - 1'b1;
    end
  end

  assign top = ent[0];
endmodule

// File: rtl/irq_ctrl_stack.sv
module irq_ctrl_stack
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_EXT   = 3,
  parameter int NUM_INT   = 4,
  parameter int PC_W      = 16,
  parameter int STK_DEPTH = 8,
  localparam int NM       = NUM_EXT + NUM_INT,
  localparam int VEC_W    = $clog2(NM + MASK_BASE) + 1,
  localparam int LVL_W    = $clog2(STK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_irq,
  input  logic             nmi_n,
  input  logic [NUM_EXT-1:0] ext_irq_n,
  input  logic [NUM_INT-1:0] int_irq,
  input  logic [NM-1:0]    flag_set,
  input  logic [NM-1:0]    flag_clr,
  output logic [NM-1:0]    flag_q,
  input  logic             mask_we,
  input  logic [NM-1:0]    mask_d,
  output logic [NM-1:0]    mask_q,
  input  logic             gdis_clr,
  output logic             gdis_q,
  input  logic             busy,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vec,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             call_push,
  input  logic             ret_pop,
  output logic [PC_W-1:0]  ret_pc,
  output logic [LVL_W-1:0] stk_level,
  output logic             stk_ovf
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;
  localparam int SW = VEC_W - 1;

  logic [NUM_EXT:0] fall;
  logic [NM-1:0]    hw_ev, enabled, acc_clr;
  logic             rst_pend, nmi_pend, any_m, acc;
  logic [IW-1:0]    idx_m;
  logic [SW-1:0]    src_num;
  src_kind_e        kind;

  irq_sync_edge #(.W(NUM_EXT + 1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_n ({nmi_n, ext_irq_n}),
    .fall   (fall)
  );

  assign hw_ev   = {int_irq, fall[NUM_EXT-1:0]};
  assign enabled = flag_q & mask_q & {NM{~gdis_q}};

  irq_prio_enc #(.N(NM)) u_enc (
    .req (enabled),
    .any (any_m),
    .idx (idx_m)
  );

  always_comb begin
    if (rst_pend) begin
      kind    = SRC_RESET;
      src_num = '0;
    end else if (nmi_pend) begin
      kind    = SRC_NMI;
      src_num = SW'(1);
    end else if (any_m) begin
      kind    = SRC_MASKABLE;
      src_num = SW'(idx_m) + SW'(MASK_BASE);
    end else begin
      kind    = SRC_NONE;
      src_num = '0;
    end
  end

  assign irq_vec   = {src_num, 1'b0};
  assign irq_valid = (kind != SRC_NONE) && !busy;
  assign acc       = irq_valid && irq_ready;
  assign acc_clr   = (acc && kind == SRC_MASKABLE) ? (NM'(1) << idx_m) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      mask_q   <= '0;
      gdis_q   <= 1'b1;
      rst_pend <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      flag_q   <= (flag_q & ~flag_clr & ~acc_clr) | hw_ev | (flag_set & ~flag_clr);
      if (mask_we) mask_q <= mask_d;
      if (acc && (kind == SRC_MASKABLE || kind == SRC_RESET)) gdis_q <= 1'b1;
      else if (gdis_clr)                                      gdis_q <= 1'b0;
      rst_pend <= rst_irq | (rst_pend & ~(acc && kind == SRC_RESET));
      nmi_pend <= fall[NUM_EXT] | (nmi_pend & ~(acc && kind == SRC_NMI));
    end
  end

  logic st_clear, st_push, st_pop;
  assign st_clear = acc && kind == SRC_RESET;
  assign st_push  = acc ? (kind != SRC_RESET) : call_push;
  assign st_pop   = !acc && !call_push && ret_pop;

  irq_ret_stack #(.DEPTH(STK_DEPTH), .DW(PC_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (st_clear),
    .push  (st_push),
    .pop   (st_pop),
    .din   (pc_in),
    .top   (ret_pc),
    .level (stk_level),
    .ovf   (stk_ovf)
  );
endmodule

// File: rtl/irq_ctrl_stack_chk.sv
module irq_ctrl_stack_chk #(
  parameter int NM    = 7,
  parameter int VEC_W = 5,
  parameter int LVL_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [VEC_W-1:0] irq_vec,
  input logic             gdis_q,
  input logic [NM-1:0]    mask_q,
  input logic [NM-1:0]    flag_q,
  input logic             call_push,
  input logic             ret_pop,
  input logic [LVL_W-1:0] stk_level,
  input logic             stk_ovf
);
  logic acc, acc_rst, acc_msk;
  assign acc     = irq_valid && irq_ready;
  assign acc_rst = acc && irq_vec == '0;
  assign acc_msk = acc && irq_vec >= VEC_W'(4);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_valid);

  assert_vec_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vec[0] == 1'b0);

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vec >= VEC_W'(4)) |-> (!gdis_q && (flag_q & mask_q) != '0));

  assert_gdis_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_msk |=> gdis_q);

  assert_rst_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rst |=> (stk_level == '0 && !stk_ovf && gdis_q));

  assert_call_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && call_push && stk_level < LVL_W'(DEPTH)) |=> stk_level == $past(stk_level) + 1'b1);

  assert_no_overflow_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_level <= LVL_W'(DEPTH));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_ovf && !acc_rst) |=> stk_ovf);

  assert_pop_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !call_push && ret_pop && stk_level == '0) |=> stk_level == '0);
endmodule

bind irq_ctrl_stack irq_ctrl_stack_chk #(
  .NM(NM), .VEC_W(VEC_W), .LVL_W(LVL_W), .DEPTH(STK_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .irq_valid (irq_valid),
  .irq_ready (irq_ready),
  .irq_vec   (irq_vec),
  .gdis_q    (gdis_q),
  .mask_q    (mask_q),
  .flag_q    (flag_q),
  .call_push (call_push),
  .ret_pop   (ret_pop),
  .stk_level (stk_level),
  .stk_ovf   (stk_ovf)
);

// File: tb/test_irq_ctrl_stack.sv
module test_irq_ctrl_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_irq = 1'b0, nmi_n = 1'b1;
  logic [2:0]  ext_irq_n = 3'b111;
  logic [3:0]  int_irq = '0;
  logic [6:0]  flag_set = '0, flag_clr = '0, mask_d = '0;
  logic        mask_we = 1'b0, gdis_clr = 1'b0, busy = 1'b0, irq_ready = 1'b0;
  logic [15:0] pc_in = '0;
  logic        call_push = 1'b0, ret_pop = 1'b0;
  logic [6:0]  flag_q, mask_q;
  logic        gdis_q, irq_valid, stk_ovf;
  logic [4:0]  irq_vec;
  logic [15:0] ret_pc;
  logic [3:0]  stk_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl_stack i_irq_ctrl_stack (
    .clk(clk), .rst_n(rst_n), .rst_irq(rst_irq), .nmi_n(nmi_n),
    .ext_irq_n(ext_irq_n), .int_irq(int_irq), .flag_set(flag_set),
    .flag_clr(flag_clr), .flag_q(flag_q), .mask_we(mask_we), .mask_d(mask_d),
    .mask_q(mask_q), .gdis_clr(gdis_clr), .gdis_q(gdis_q), .busy(busy),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vec(irq_vec),
    .pc_in(pc_in), .call_push(call_push), .ret_pop(ret_pop), .ret_pc(ret_pc),
    .stk_level(stk_level), .stk_ovf(stk_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 flags", 32'(flag_q), 0);
    chk("R1 mask", 32'(mask_q), 0);
    chk("R1 gdis", 32'(gdis_q), 1);
    chk("R1 level", 32'(stk_level), 0);
    chk("R1 ovf", 32'(stk_ovf), 0);
    chk("R1 valid", 32'(irq_valid), 0);
  endtask

  task automatic t_sw_flags();
    flag_set = 7'b0000101; step(); flag_set = '0;
    chk("R3 set", 32'(flag_q), 32'h05);
    chk("R4 masked not offered", 32'(irq_valid), 0);
    flag_set = 7'b0000010; flag_clr = 7'b0000011; step();
    flag_set = '0; flag_clr = '0;
    chk("R3 clear wins", 32'(flag_q), 32'h04);
    flag_clr = '1; step(); flag_clr = '0;
    chk("R3 clear all", 32'(flag_q), 0);
  endtask

  task automatic t_edge();
    ext_irq_n[1] = 1'b0;
    step(); step();
    chk("R2 sync latency", 32'(flag_q), 0);
    step();
    chk("R2 ext edge", 32'(flag_q), 32'h02);
    flag_clr = 7'b0000010; step(); flag_clr = '0;
    step(); step();
    chk("R2 held low once", 32'(flag_q), 0);
    ext_irq_n[1] = 1'b1;
    int_irq[2] = 1'b1; step(); int_irq[2] = 1'b0;
    chk("R2 internal pulse", 32'(flag_q), 32'h20);
    step(); step(); step();
    chk("R2 rising ignored", 32'(flag_q), 32'h20);
    flag_clr = '1; step(); flag_clr = '0;
  endtask

  task automatic t_stack_basic();
    pc_in = 16'h0111; call_push = 1'b1; step();
    pc_in = 16'h0222; step(); call_push = 1'b0;
    chk("R10 level", 32'(stk_level), 2);
    chk("R10 top", 32'(ret_pc), 32'h0222);
    ret_pop = 1'b1; step(); ret_pop = 1'b0;
    chk("R10 pop top", 32'(ret_pc), 32'h0111);
    chk("R10 pop level", 32'(stk_level), 1);
    pc_in = 16'h0333; call_push = 1'b1; ret_pop = 1'b1; step();
    call_push = 1'b0; ret_pop = 1'b0;
    chk("R10 push wins", 32'(stk_level), 2);
    chk("R10 push wins top", 32'(ret_pc), 32'h0333);
  endtask

  task automatic t_prio();
    gdis_clr = 1'b1; step(); gdis_clr = 1'b0;
    flag_set = 7'b1100010; step(); flag_set = '0;
    chk("R4 mask zero", 32'(irq_valid), 0);
    chk("R4 flags kept", 32'(flag_q), 32'h62);
    mask_we = 1'b1; mask_d = 7'b1100000; step(); mask_we = 1'b0;
    chk("R5 timer over uart valid", 32'(irq_valid), 1);
    chk("R5 timer vector", 32'(irq_vec), 14);
    mask_we = 1'b1; mask_d = '1; step(); mask_we = 1'b0;
    chk("R5 ext1 vector", 32'(irq_vec), 6);
    nmi_n = 1'b0; step(); step(); step(); nmi_n = 1'b1;
    chk("R5 nmi vector", 32'(irq_vec), 2);
    rst_irq = 1'b1; step(); rst_irq = 1'b0;
    chk("R5 reset vector", 32'(irq_vec), 0);
  endtask

  task automatic t_busy();
    busy = 1'b1; #1;
    chk("R6 busy blocks", 32'(irq_valid), 0);
    irq_ready = 1'b1; step(); irq_ready = 1'b0;
    chk("R6 nothing taken", 32'(stk_level), 2);
    busy = 1'b0; #1;
    chk("R6 offer resumes", 32'(irq_vec), 0);
    chk("R6 valid resumes", 32'(irq_valid), 1);
  endtask

  task automatic t_accepts();
    gdis_clr = 1'b1; step(); gdis_clr = 1'b0;
    pc_in = 16'h0F0F; irq_ready = 1'b1; step(); irq_ready = 1'b0;
    chk("R9 stack empty", 32'(stk_level), 0);
    chk("R9 gdis", 32'(gdis_q), 1);
    chk("R9 nmi next", 32'(irq_vec), 2);
    pc_in = 16'h0AAA; irq_ready = 1'b1; step(); irq_ready = 1'b0;
    chk("R8 nmi push", 32'(ret_pc), 32'h0AAA);
    chk("R8 nmi level", 32'(stk_level), 1);
    chk("R8 gdis unchanged", 32'(gdis_q), 1);
    chk("R4 gdis blocks", 32'(irq_valid), 0);
    gdis_clr = 1'b1; step(); gdis_clr = 1'b0;
    chk("R7 offer ext1", 32'(irq_vec), 6);
    pc_in = 16'h0BBB; irq_ready = 1'b1; step(); irq_ready = 1'b0;
    chk("R7 push", 32'(ret_pc), 32'h0BBB);
    chk("R7 level", 32'(stk_level), 2);
    chk("R7 flag cleared", 32'(flag_q), 32'h60);
    chk("R7 gdis set", 32'(gdis_q), 1);
    ret_pop = 1'b1; step();
    chk("R10 return order", 32'(ret_pc), 32'h0AAA);
    step(); ret_pop = 1'b0;
    chk("R10 empty", 32'(stk_level), 0);
  endtask

  task automatic t_overflow();
    call_push = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      pc_in = 16'(16'h1000 + i); step();
      if (i == 8) chk("R11 full no ovf", 32'(stk_ovf), 0);
    end
    call_push = 1'b0;
    chk("R11 ovf", 32'(stk_ovf), 1);
    chk("R11 level", 32'(stk_level), 8);
    for (int i = 9; i >= 2; i--) begin
      chk("R11 pop order", 32'(ret_pc), 32'(16'h1000 + i));
      ret_pop = 1'b1; step(); ret_pop = 1'b0;
    end
    chk("R12 level zero", 32'(stk_level), 0);
    chk("R12 bottom value", 32'(ret_pc), 32'h1002);
    ret_pop = 1'b1; step(); ret_pop = 1'b0;
    chk("R12 stays empty", 32'(stk_level), 0);
    chk("R12 bottom kept", 32'(ret_pc), 32'h1002);
    chk("R11 ovf sticky", 32'(stk_ovf), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_flags();
    t_edge();
    t_stack_basic();
    t_prio();
    t_busy();
    t_accepts();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule